// File: doc/BRIEF.md
# Interleaved Dual-Bank Text Character Fetch

This block produces the stream of character codes for an 80-column text screen. The screen memory is split into two half-width banks. One bank holds the even-numbered columns and the other holds the odd-numbered columns. Both banks are reached through one shared address bus. On a single video fetch, both banks are read at the same time into their own output latches. The two latches then drive the one character-code bus in turn: first the even column for one character time, then the odd column for the next. A downstream character generator therefore sees one column per character time, while each RAM is accessed only once per two columns.

Every memory cycle spans two clocks: a video slot followed by a CPU slot. In the CPU slot the host's address and write data take over the bank address and data paths, so the host can read or write either bank. In the video slot the fetch counter owns the banks. Host address bit 0 selects the bank, and the remaining bits give the location inside the bank. Each bank has its own read strobe, write strobe and latch strobe. The address and write data are common to both banks.

Top module: `textfetch_dual_bank`

## Requirements
- R1: While reset is high, `char_code` is 0x00, and `code_valid`, `char_first` and `cpu_ack` are all 0.
- R2: Host address bit 0 selects the odd bank (1) or the even bank (0), and address bits above bit 0 give the location inside that bank. A write followed by a read of the same address returns the written byte. Neighbouring even and odd addresses hold independent bytes.
- R3: Screen position p (row-major, column 0 at the left edge) displays the byte written at host address p. Even positions come from the even bank and odd positions from the odd bank. Only one bank latch drives the code bus at a time.
- R4: Each displayed code stays on `char_code` for exactly 2 clock cycles. `char_first` is high exactly while screen position 0 is displayed, and it recurs every 2·COLS·ROWS cycles.
- R5: A host request held high is served in the CPU slot. It is acknowledged by a one-cycle `cpu_ack` pulse no more than 2 cycles after the request is raised. Read data is valid on `cpu_rdata` while `cpu_ack` is high.
- R6: A host write never changes the codes already latched for the pair on display. The new byte appears only when its pair is next fetched.
- R7: A host address at or above COLS·ROWS writes nothing, reads back 0x00, and does not alias any screen location.
- R8: After the last screen position (COLS·ROWS−1), the stream wraps to position 0 with `char_first` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Host access request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 11 | Host screen address (bit 0 = bank select) |
| cpu_wdata | input | 8 | Host write byte |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_ack` |
| char_code | output | 8 | Character code to the character generator |
| code_valid | output | 1 | High once the first pair has been fetched |
| char_first | output | 1 | High while screen position 0 is on `char_code` |

## Verification
The bench fills the whole screen with a repeating 0x00–0xFF ramp through the host port. It then follows a full frame column by column. A design that swapped the banks, shared one latch, or advanced the fetch counter every character time would show the ramp out of order or with repeated bytes. The bench also checks the two-cycle hold and the wrap from the last position back to position 0, which is where an off-by-one fetch counter would skip or repeat a pair. It writes the odd half of the pair on display: a design that read the RAM directly instead of the latch would show the new byte one frame too early. Finally, it writes and reads just past the screen, which catches a decoder that wraps out-of-range addresses onto real locations.

// File: rtl/tfd_pkg.sv
package tfd_pkg;

    // Which owner has the bank address/data paths during the current clock.
    typedef enum logic {
        SLOT_VIDEO = 1'b0,
        SLOT_CPU   = 1'b1
    } slot_e;

    typedef enum logic {
        BANK_EVEN = 1'b0,
        BANK_ODD  = 1'b1
    } bank_e;

    // Per-bank control strobes; address and data are shared by both banks.
    typedef struct packed {
        logic rd;
        logic wr;
        logic lat;
    } bank_strobe_t;

    function automatic bank_e bank_of(input logic addr_lsb);
        return addr_lsb ? BANK_ODD : BANK_EVEN;
    endfunction

endpackage

// File: rtl/tfd_timing.sv
module tfd_timing
    import tfd_pkg::*;
#(
    parameter int DEPTH = 1000,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst,
    output slot_e         slot,
    output logic [AW-1:0] vaddr,
    output logic          lat_stb,
    output logic          even_oe,
    output logic          odd_oe,
    output logic          first_col,
    output logic          valid
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    logic pair_phase;   // 0: next video slot fetches a new pair
    logic show_odd;
    logic pair_first;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot       <= SLOT_VIDEO;
            pair_phase <= 1'b0;
            vaddr      <= '0;
            show_odd   <= 1'b0;
            pair_first <= 1'b0;
            valid      <= 1'b0;
        end else begin
            slot <= (slot == SLOT_VIDEO) ? SLOT_CPU : SLOT_VIDEO;
            if (slot == SLOT_VIDEO) begin
                pair_phase <= ~pair_phase;
                if (!pair_phase) begin
                    show_odd   <= 1'b0;
                    valid      <= 1'b1;
                    pair_first <= (vaddr == '0);
                    vaddr      <= (vaddr == LAST_ADDR) ? '0 : vaddr + 1'b1;
                end else begin
                    show_odd <= 1'b1;
                end
            end
        end
    end

    // Both bank latches capture at the video edge that opens a new pair.
    assign lat_stb   = (slot == SLOT_VIDEO) && !pair_phase;
    assign even_oe   = valid && !show_odd;
    assign odd_oe    = valid && show_odd;
    assign first_col = pair_first && even_oe;

endmodule

// File: rtl/tfd_bank.sv
module tfd_bank
    import tfd_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 1000,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  bank_strobe_t  stb,
    output logic [DW-1:0] rd_q,
    output logic [DW-1:0] lat_q
);

    logic [DW-1:0] mem [DEPTH];
    logic          in_range;

    assign in_range = (int'(addr) < DEPTH);

    always_ff @(posedge clk) begin
        if (stb.wr && in_range) begin
            mem[addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            lat_q <= '0;
        end else begin
            if (stb.rd) begin
                rd_q <= in_range ? mem[addr] : '0;
            end
            if (stb.lat) begin
                lat_q <= in_range ? mem[addr] : '0;
            end
        end
    end

endmodule

// File: rtl/tfd_cpu_port.sv
module tfd_cpu_port
    import tfd_pkg::*;
#(
    parameter int DW  = 8,
    parameter int AW  = 10,
    parameter int CAW = 11
) (
    input  logic           clk,
    input  logic           rst,
    input  slot_e          slot,
    input  logic           cpu_req,
    input  logic           cpu_we,
    input  logic [CAW-1:0] cpu_addr,
    input  logic [DW-1:0]  rd_q_even,
    input  logic [DW-1:0]  rd_q_odd,
    output logic [AW-1:0]  bank_addr,
    output logic [1:0]     rd_stb,
    output logic [1:0]     wr_stb,
    output logic           cpu_ack,
    output logic [DW-1:0]  cpu_rdata
);

    logic  go;
    bank_e sel_bank;
    bank_e sel_r;

    assign go        = (slot == SLOT_CPU) && cpu_req;
    assign sel_bank  = bank_of(cpu_addr[0]);
    assign bank_addr = AW'(cpu_addr >> 1);

    for (genvar b = 0; b < 2; b++) begin : g_strobe
        assign rd_stb[b] = go && !cpu_we && (sel_bank == bank_e'(b));
        assign wr_stb[b] = go &&  cpu_we && (sel_bank == bank_e'(b));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_ack <= 1'b0;
            sel_r   <= BANK_EVEN;
        end else begin
            cpu_ack <= go;
            if (go) begin
                sel_r <= sel_bank;
            end
        end
    end

    assign cpu_rdata = (sel_r == BANK_ODD) ? rd_q_odd : rd_q_even;

endmodule

// File: rtl/textfetch_dual_bank.sv
module textfetch_dual_bank
    import tfd_pkg::*;
#(
    parameter int COLS = 80,
    parameter int ROWS = 25,
    parameter int DW   = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            cpu_req,
    input  logic                            cpu_we,
    input  logic [$clog2(COLS*ROWS)-1:0]    cpu_addr,
    input  logic [DW-1:0]                   cpu_wdata,
    output logic                            cpu_ack,
    output logic [DW-1:0]                   cpu_rdata,
    output logic [DW-1:0]                   char_code,
    output logic                            code_valid,
    output logic                            char_first
);

    localparam int SCREEN = COLS * ROWS;
    localparam int DEPTH  = (COLS / 2) * ROWS;
    localparam int AW     = $clog2(DEPTH);
    localparam int CAW    = $clog2(SCREEN);

    slot_e          slot;
    logic [AW-1:0]  vaddr;
    logic [AW-1:0]  cpu_bank_addr;
    logic [AW-1:0]  shared_addr;
    logic           lat_stb;
    logic           even_oe;
    logic           odd_oe;
    logic [1:0]     rd_stb;
    logic [1:0]     wr_stb;
    bank_strobe_t   strb   [2];
    logic [DW-1:0]  rd_q   [2];
    logic [DW-1:0]  lat_q  [2];
    logic [DW-1:0]  even_lat;
    logic [DW-1:0]  odd_lat;

    tfd_timing #(.DEPTH(DEPTH), .AW(AW)) u_timing (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .vaddr     (vaddr),
        .lat_stb   (lat_stb),
        .even_oe   (even_oe),
        .odd_oe    (odd_oe),
        .first_col (char_first),
        .valid     (code_valid)
    );

    tfd_cpu_port #(.DW(DW), .AW(AW), .CAW(CAW)) u_cpu (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .rd_q_even (rd_q[0]),
        .rd_q_odd  (rd_q[1]),
        .bank_addr (cpu_bank_addr),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .cpu_ack   (cpu_ack),
        .cpu_rdata (cpu_rdata)
    );

    // Host takes over the shared bank address in its slot.
    assign shared_addr = (slot == SLOT_CPU) ? cpu_bank_addr : vaddr;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        assign strb[b] = '{rd: rd_stb[b], wr: wr_stb[b], lat: lat_stb};

        tfd_bank #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .addr  (shared_addr),
            .wdata (cpu_wdata),
            .stb   (strb[b]),
            .rd_q  (rd_q[b]),
            .lat_q (lat_q[b])
        );
    end

    assign even_lat = lat_q[0];
    assign odd_lat  = lat_q[1];

    always_comb begin
        char_code = '0;
        if (even_oe) char_code = even_lat;
        if (odd_oe)  char_code = odd_lat;
    end

endmodule

// File: rtl/tfd_checker.sv
module tfd_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cpu_req,
    input logic          cpu_ack,
    input logic          slot_cpu,
    input logic [1:0]    rd_stb,
    input logic [1:0]    wr_stb,
    input logic          lat_stb,
    input logic          even_oe,
    input logic          odd_oe,
    input logic          char_first,
    input logic [DW-1:0] even_lat,
    input logic [DW-1:0] odd_lat
);

    a_r5_ack_one_cycle: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |=> !cpu_ack);

    a_r5_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |-> $past(cpu_req));

    a_r2_strobes_in_cpu_slot: assert property (@(posedge clk) disable iff (rst)
        ((|rd_stb) || (|wr_stb)) |-> slot_cpu);

    a_r2_one_bank_strobed: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_stb, wr_stb}));

    a_r3_single_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0({even_oe, odd_oe}));

    a_r4_first_is_even: assert property (@(posedge clk) disable iff (rst)
        char_first |-> (even_oe && !odd_oe));

    a_r6_even_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !lat_stb |=> $stable(even_lat));

    a_r6_odd_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !lat_stb |=> $stable(odd_lat));

endmodule

bind textfetch_dual_bank tfd_checker #(.DW(DW)) u_tfd_checker (
    .clk        (clk),
    .rst        (rst),
    .cpu_req    (cpu_req),
    .cpu_ack    (cpu_ack),
    .slot_cpu   (slot == tfd_pkg::SLOT_CPU),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .lat_stb    (lat_stb),
    .even_oe    (even_oe),
    .odd_oe     (odd_oe),
    .char_first (char_first),
    .even_lat   (even_lat),
    .odd_lat    (odd_lat)
);

// File: tb/textfetch_dual_bank_bench.sv
module textfetch_dual_bank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int COLS   = 80;
    localparam int ROWS   = 25;
    localparam int DW     = 8;
    localparam int SCREEN = COLS * ROWS;
    localparam int CAW    = $clog2(SCREEN);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cpu_req = 1'b0;
    logic           cpu_we = 1'b0;
    logic [CAW-1:0] cpu_addr = '0;
    logic [DW-1:0]  cpu_wdata = '0;
    logic           cpu_ack;
    logic [DW-1:0]  cpu_rdata;
    logic [DW-1:0]  char_code;
    logic           code_valid;
    logic           char_first;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    textfetch_dual_bank #(.COLS(COLS), .ROWS(ROWS), .DW(DW)) u_textfetch_dual_bank (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_ack    (cpu_ack),
        .cpu_rdata  (cpu_rdata),
        .char_code  (char_code),
        .code_valid (code_valid),
        .char_first (char_first)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
        end
    endtask

    // Host access; checks R5 latency and pulse width on every call.
    task automatic host_access(input bit we, input int addr, input int wd, output int rd);
        int waited = 0;
        cpu_we    = we;
        cpu_addr  = CAW'(addr);
        cpu_wdata = DW'(wd);
        cpu_req   = 1'b1;
        do begin
            @(negedge clk);
            waited++;
        end while (!cpu_ack && waited < 8);
        rd = int'(cpu_rdata);
        cpu_req = 1'b0;
        if (waited > 2) check("R5 ack latency", waited, 2);
        @(negedge clk);
        if (cpu_ack) check("R5 ack width", 1, 0);
    endtask

    task automatic host_write(input int addr, input int wd);
        int dummy;
        host_access(1'b1, addr, wd, dummy);
    endtask

    task automatic host_read(input int addr, output int rd);
        host_access(1'b0, addr, 0, rd);
    endtask

    task automatic wait_first();
        int guard = 0;
        while (!char_first && guard < 3 * 2 * SCREEN) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 code", int'(char_code), 0);
        check("R1 valid", int'(code_valid), 0);
        check("R1 first", int'(char_first), 0);
        check("R1 ack", int'(cpu_ack), 0);
        rst = 1'b0;
    endtask

    task automatic t_bank_map();
        int rd;
        host_write(10, 8'h11);
        host_write(11, 8'h22);
        host_read(10, rd);
        check("R2 even readback", rd, 8'h11);
        host_read(11, rd);
        check("R2 odd readback", rd, 8'h22);
        host_write(11, 8'h33);
        host_read(10, rd);
        check("R2 even untouched by odd write", rd, 8'h11);
    endtask

    task automatic t_fill();
        for (int a = 0; a < SCREEN; a++) host_write(a, a & 8'hFF);
    endtask

    task automatic t_stream();
        int bad_code = 0;
        int bad_hold = 0;
        int bad_first = 0;
        wait_first();
        for (int p = 0; p < SCREEN; p++) begin
            if (int'(char_code) != (p & 8'hFF)) bad_code++;
            if (char_first != (p == 0)) bad_first++;
            @(negedge clk);
            if (int'(char_code) != (p & 8'hFF)) bad_hold++;
            @(negedge clk);
        end
        check("R3 column order mismatches", bad_code, 0);
        check("R4 two-cycle hold mismatches", bad_hold, 0);
        check("R4 first flag mismatches", bad_first, 0);
        check("R8 wrap first flag", int'(char_first), 1);
        check("R8 wrap code", int'(char_code), 8'h00);
        check("R3 valid", int'(code_valid), 1);
    endtask

    task automatic t_period();
        int cyc = 0;
        wait_first();
        while (char_first) @(negedge clk);
        cyc = 2;
        while (!char_first && cyc < 3 * 2 * SCREEN) begin
            @(negedge clk);
            cyc++;
        end
        check("R4 frame period", cyc, 2 * SCREEN);
    endtask

    task automatic t_no_disturb();
        wait_first();
        host_write(1, 8'hC3);
        while (char_first) @(negedge clk);
        check("R6 displayed pair unchanged", int'(char_code), 8'h01);
        wait_first();
        @(negedge clk);
        @(negedge clk);
        check("R6 new byte next frame", int'(char_code), 8'hC3);
        host_write(1, 8'h01);
    endtask

    task automatic t_out_of_range();
        int rd;
        host_write(SCREEN, 8'h5A);
        host_write(SCREEN + 1, 8'hA5);
        host_read(SCREEN, rd);
        check("R7 read past screen", rd, 0);
        host_read(0, rd);
        check("R7 no alias at 0", rd, 8'h00);
        host_read(SCREEN - 1, rd);
        check("R7 last location intact", rd, (SCREEN - 1) & 8'hFF);
    endtask

    initial begin
        t_reset();
        t_bank_map();
        t_fill();
        t_stream();
        t_period();
        t_no_disturb();
        t_out_of_range();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule